// File: doc/BRIEF.md
# Dual-Converter Serial ADC Sequencer

This block runs single conversions on two external serial analog-to-digital converters. Both converters share one serial clock, one command line and one return line, and each has its own active-low chip select. The host presents a 4-bit channel code and raises a start request. The block then selects one converter, clocks out the three-bit input address, clocks in a 10-bit sample, stores it and raises a valid flag.

The serial clock is derived from the system clock by a half-period parameter. A frame is sixteen serial clock pulses long. Each slot starts with the serial clock low for `HALF_DIV` system cycles and ends with it high for `HALF_DIV` cycles. The address occupies the first three slots, most significant bit first. The sample is taken on the rising serial clock edges of slots 4 through 13, most significant bit first.

Top module: `dual_adc_seq`

## Requirements
- R1: After reset both chip selects are high, the serial clock and the command line are low, the valid flag is low and the result is zero.
- R2: Channel code bit 3 picks the converter: 0 drives `cs_n_o[0]` low and 1 drives `cs_n_o[1]` low. The chip select goes low on the clock edge that sees the start edge. At no time are both chip selects low.
- R3: During slots 0, 1 and 2 the command line carries channel code bits 2, 1 and 0 in that order. It is low in every other slot. It changes only while the serial clock is low.
- R4: The serial clock idles low whenever both chip selects are high. Within a frame it spends `HALF_DIV` system cycles low and then `HALF_DIV` high in each of 16 slots, so the frame has exactly 16 rising edges.
- R5: The result holds the return line values sampled at the rising serial clock edges of slots 4 to 13, with the slot 4 bit as result bit 9 and the slot 13 bit as result bit 0.
- R6: The valid flag is low from the edge that sees the start request. It rises exactly 32*`HALF_DIV` system cycles later, on the same edge at which the result updates and the chip select returns high.
- R7: A start is taken only on a rising edge of `go_i`. Holding `go_i` high starts no further frame. A rising edge during a frame is ignored.
- R8: Changing the channel code without a start edge leaves the valid flag, the result and the chip selects unchanged.
- R9: The result changes only at the end of a frame. It keeps its previous value throughout a conversion.
- R10: Both chip selects are high between frames and at the moment the valid flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start request, acted on at its rising edge |
| chan_i | input | 4 | Channel code: bit 3 selects the converter, bits 2:0 the input |
| sclk_o | output | 1 | Shared serial clock |
| cs_n_o | output | 2 | Active-low chip selects, one per converter |
| mosi_o | output | 1 | Shared command line carrying the address |
| miso_i | input | 1 | Shared return line carrying the sample |
| result_o | output | 10 | Last completed sample |
| valid_o | output | 1 | High when `result_o` holds the sample of the last started conversion |

## Verification
The bench builds the block with `HALF_DIV` = 2 and keeps the frame, address and result widths at their defaults. With these values one frame takes 64 system cycles. That makes a sweep of all sixteen channel codes, each with five return patterns, cheap to run. The slow clock still leaves a separate low and high phase in every slot, so a sample taken on the wrong phase of the serial clock gives a wrong result. The bench also checks the exact valid-rise cycle, a start edge injected in the middle of a frame, a start request held high, and channel changes made while idle.

// File: rtl/dual_adc_seq_pkg.sv
package dual_adc_seq_pkg;
    // Sequencer phases: waiting for a start edge, or running a frame.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/dual_adc_sclk_gen.sv
// Serial clock generator.
// Produces a serial clock that is low for HALF_DIV system cycles and then
// high for HALF_DIV cycles while run_i is set. It also produces one-cycle
// strobes that mark the system edge at which the serial clock rises or falls.
// Assumes run_i comes from a register and HALF_DIV >= 1.
module dual_adc_sclk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             sclk_q;
    logic             wrap;

    // Phase end: the divider has counted a full half period.
    assign wrap       = run_i && (cnt_q == CNT_LAST);
    assign rise_stb_o = wrap && !sclk_q;
    assign fall_stb_o = wrap &&  sclk_q;
    assign sclk_o     = sclk_q;

    // Divider counter and serial clock toggle; both rest at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dual_adc_frame_ctrl.sv
// Frame controller.
// Detects the rising edge of the start request and latches the channel code.
// Drives the chip select of the converter named by the top channel bit, and
// counts serial clock slots until the frame ends. A start edge seen while a
// frame runs is dropped. Assumes NUM_CONV chip selects, indexed by the top
// channel bits.
module dual_adc_frame_ctrl
    import dual_adc_seq_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int SEL_W     = 1,
    parameter int FRAME_LEN = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go_i,
    input  logic [ADDR_W+SEL_W-1:0] chan_i,
    input  logic                    fall_stb_i,
    output logic                    run_o,
    output logic                    start_o,
    output logic                    done_o,
    output logic [$clog2(FRAME_LEN)-1:0] slot_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [(1<<SEL_W)-1:0]   cs_n_o
);
    localparam int NUM_CONV = 1 << SEL_W;
    localparam int IDX_W    = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(FRAME_LEN - 1);

    seq_state_t          state_q;
    logic                go_q;
    logic [IDX_W-1:0]    slot_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [NUM_CONV-1:0] cs_n_q;
    logic [NUM_CONV-1:0] hit;

    // Per-converter decode of the select field of the incoming code.
    for (genvar g = 0; g < NUM_CONV; g++) begin : g_sel
        assign hit[g] = (chan_i[ADDR_W +: SEL_W] == SEL_W'(g));
    end

    assign start_o = go_i && !go_q && (state_q == SEQ_IDLE);
    assign done_o  = fall_stb_i && (slot_q == SLOT_LAST);
    assign run_o   = (state_q == SEQ_RUN);
    assign slot_o  = slot_q;
    assign addr_o  = addr_q;
    assign cs_n_o  = cs_n_q;

    // Start request history for rising edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= go_i;
    end

    // Sequencer state, slot counter, latched address and chip selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            addr_q  <= '0;
            cs_n_q  <= '1;
        end else if (start_o) begin
            state_q <= SEQ_RUN;
            slot_q  <= '0;
            addr_q  <= chan_i[ADDR_W-1:0];
            cs_n_q  <= ~hit;
        end else if (done_o) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            cs_n_q  <= '1;
        end else if (fall_stb_i) begin
            slot_q  <= slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/dual_adc_shift_unit.sv
// Shift unit.
// Presents the address bits on the command line, one per slot, most
// significant bit first. Gathers the sample bits from the return line at
// the rising serial clock edges of the result window. Commits the sample
// to the result register and raises valid when the frame ends. Assumes the
// strobes come from the serial clock generator and the frame controller.
module dual_adc_shift_unit #(
    parameter int ADDR_W    = 3,
    parameter int RES_W     = 10,
    parameter int RES_FIRST = 4,
    parameter int FRAME_LEN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         done_i,
    input  logic                         rise_stb_i,
    input  logic                         fall_stb_i,
    input  logic [$clog2(FRAME_LEN)-1:0] slot_i,
    input  logic [ADDR_W-1:0]            start_addr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         miso_i,
    output logic                         mosi_o,
    output logic [RES_W-1:0]             result_o,
    output logic                         valid_o
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic             mosi_q;
    logic [RES_W-1:0] cap_q;
    logic [RES_W-1:0] res_q;
    logic             valid_q;
    logic             in_window;

    // Command line value for a given slot: address bits first, then zero.
    function automatic logic slot_bit(input logic [IDX_W-1:0] idx,
                                      input logic [ADDR_W-1:0] a);
        logic b;
        b = 1'b0;
        for (int k = 0; k < ADDR_W; k++) begin
            if (int'(idx) == k) b = a[ADDR_W-1-k];
        end
        return b;
    endfunction

    assign in_window = (int'(slot_i) >= RES_FIRST) &&
                       (int'(slot_i) <  RES_FIRST + RES_W);
    assign mosi_o    = mosi_q;
    assign result_o  = res_q;
    assign valid_o   = valid_q;

    // Command line: loaded at start, advanced on each serial clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)          mosi_q <= 1'b0;
        else if (start_i)    mosi_q <= slot_bit('0, start_addr_i);
        else if (done_i)     mosi_q <= 1'b0;
        else if (fall_stb_i) mosi_q <= slot_bit(slot_i + 1'b1, addr_i);
    end

    // Sample gathering on rising serial clock edges inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cap_q <= '0;
        else if (rise_stb_i && in_window) cap_q <= {cap_q[RES_W-2:0], miso_i};
    end

    // Result register and valid flag: cleared by start, set at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else if (start_i) begin
            valid_q <= 1'b0;
        end else if (done_i) begin
            res_q   <= cap_q;
            valid_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_adc_seq.sv
// Dual-converter serial ADC sequencer, top level.
// Ties the serial clock generator, frame controller and shift unit together.
// Two converters share the serial clock and data lines. The top bit of the
// channel code steers the chip select. Assumes the return line is stable
// around the rising edges of the serial clock.
module dual_adc_seq #(
    parameter int HALF_DIV  = 4,
    parameter int ADDR_W    = 3,
    parameter int RES_W     = 10,
    parameter int RES_FIRST = 4,
    parameter int FRAME_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W:0]   chan_i,
    output logic              sclk_o,
    output logic [1:0]        cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [RES_W-1:0]  result_o,
    output logic              valid_o
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic              run;
    logic              start;
    logic              done;
    logic              rise_stb;
    logic              fall_stb;
    logic [IDX_W-1:0]  slot;
    logic [ADDR_W-1:0] addr;

    dual_adc_sclk_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .sclk_o     (sclk_o),
        .rise_stb_o (rise_stb),
        .fall_stb_o (fall_stb)
    );

    dual_adc_frame_ctrl #(
        .ADDR_W    (ADDR_W),
        .SEL_W     (1),
        .FRAME_LEN (FRAME_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_i),
        .chan_i     (chan_i),
        .fall_stb_i (fall_stb),
        .run_o      (run),
        .start_o    (start),
        .done_o     (done),
        .slot_o     (slot),
        .addr_o     (addr),
        .cs_n_o     (cs_n_o)
    );

    dual_adc_shift_unit #(
        .ADDR_W    (ADDR_W),
        .RES_W     (RES_W),
        .RES_FIRST (RES_FIRST),
        .FRAME_LEN (FRAME_LEN)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .done_i       (done),
        .rise_stb_i   (rise_stb),
        .fall_stb_i   (fall_stb),
        .slot_i       (slot),
        .start_addr_i (chan_i[ADDR_W-1:0]),
        .addr_i       (addr),
        .miso_i       (miso_i),
        .mosi_o       (mosi_o),
        .result_o     (result_o),
        .valid_o      (valid_o)
    );
endmodule

// File: rtl/dual_adc_seq_chk.sv
// Protocol checker for the sequencer, attached to every instance by bind.
// It watches only the ports of the top module.
module dual_adc_seq_chk #(
    parameter int ADDR_W = 3,
    parameter int RES_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go_i,
    input logic [1:0]       cs_n_o,
    input logic             sclk_o,
    input logic             mosi_o,
    input logic [RES_W-1:0] result_o,
    input logic             valid_o
);
    // R2: never both converters selected.
    p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R4: serial clock idles low outside a frame.
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o == 2'b11) |-> !sclk_o);

    // R4: serial clock moves only inside a frame.
    p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o != $past(sclk_o)) |-> ($past(cs_n_o) != 2'b11));

    // R3: command line steady while the serial clock is high.
    p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R6: a start edge while idle clears valid on the next cycle.
    p_valid_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(go_i) && cs_n_o == 2'b11) |=> !valid_o);

    // R9: result moves only together with a rising valid flag.
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o != $past(result_o)) |-> (valid_o && !$past(valid_o)));

    // R10: chip selects released when valid rises.
    p_cs_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (cs_n_o == 2'b11));
endmodule

bind dual_adc_seq dual_adc_seq_chk #(
    .ADDR_W (ADDR_W),
    .RES_W  (RES_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .result_o (result_o),
    .valid_o  (valid_o)
);

// File: tb/dual_adc_seq_tb_top.sv
module dual_adc_seq_tb_top;
    localparam int HALF  = 2;
    localparam int FRAME = 32 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [3:0] chan = 4'd0;
    logic       sclk;
    logic [1:0] cs_n;
    logic       mosi;
    logic       miso = 1'b0;
    logic [9:0] result;
    logic       valid;

    int checks = 0;
    int failures = 0;

    // Converter model state
    logic [9:0] model_data = 10'd0;
    logic       prev_sclk = 1'b0;
    bit         active = 1'b0;
    int         slot = 0;
    int         rises = 0;
    int         last_rises = 0;
    int         frames = 0;
    logic [2:0] addr_seen = 3'd0;
    logic [2:0] last_addr = 3'd0;
    logic [1:0] cs_seen = 2'b11;
    int         mosi_bad = 0;

    always #10 clk = ~clk;

    dual_adc_seq #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .chan_i(chan),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso),
        .result_o(result), .valid_o(valid)
    );

    // Behavioural converter pair, observed away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cs_n != 2'b11) begin
            if (!active) begin
                active = 1'b1; slot = 0; rises = 0; addr_seen = 3'd0; cs_seen = cs_n;
            end
            if (sclk && !prev_sclk) begin
                rises++;
                if (slot < 3) addr_seen = {addr_seen[1:0], mosi};
                else if (mosi !== 1'b0) mosi_bad++;
            end
            if (!sclk && prev_sclk) slot++;
            miso = (slot >= 4 && slot <= 13) ? model_data[13 - slot] : 1'b0;
        end else begin
            if (active) begin
                active = 1'b0; frames++; last_rises = rises; last_addr = addr_seen;
            end
            miso = 1'b0;
        end
        prev_sclk = sclk;
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // One conversion with the full timing check; optionally a second start edge mid-frame.
    task automatic convert(input logic [3:0] c, input logic [9:0] d, input bit inject);
        logic [9:0] prev_res;
        logic [1:0] exp_cs;
        int         f0;
        bit         steady;
        prev_res   = result;
        f0         = frames;
        exp_cs     = c[3] ? 2'b01 : 2'b10;
        model_data = d;
        chan       = c;
        go         = 1'b1;
        step();                                   // start edge has passed
        check(valid == 1'b0, "R6 valid cleared", {31'd0, valid}, 32'd0);
        check(cs_n == exp_cs, "R2 chip select steering", {30'd0, cs_n}, {30'd0, exp_cs});
        steady = 1'b1;
        for (int k = 1; k < FRAME; k++) begin
            step();
            if (inject && k == 5) go = 1'b0;
            if (inject && k == 7) go = 1'b1;
            if (valid !== 1'b0 || cs_n !== exp_cs || result !== prev_res) steady = 1'b0;
        end
        check(steady, "R9 result and cs hold during frame", {22'd0, result}, {22'd0, prev_res});
        step();                                   // frame end edge has passed
        check(valid == 1'b1, "R6 valid rises at frame end", {31'd0, valid}, 32'd1);
        check(cs_n == 2'b11, "R10 cs released", {30'd0, cs_n}, 32'd3);
        check(result == d, "R5 result bits", {22'd0, result}, {22'd0, d});
        check(last_addr == c[2:0], "R3 address on command line", {29'd0, last_addr}, {29'd0, c[2:0]});
        check(last_rises == 16 && frames == f0 + 1, "R4 sixteen serial clocks", last_rises, 32'd16);
        if (inject) begin
            for (int k = 0; k < 8; k++) step();
            check(cs_n == 2'b11 && frames == f0 + 1, "R7 mid-frame start ignored", {30'd0, cs_n}, 32'd3);
        end
        go = 1'b0;
        step();
    endtask

    initial begin
        logic [9:0] pats [5];
        logic [9:0] keep;
        for (int k = 0; k < 4; k++) step();
        check(cs_n == 2'b11 && sclk == 1'b0 && mosi == 1'b0, "R1 reset outputs",
              {29'd0, cs_n, sclk}, 32'd6);
        check(valid == 1'b0 && result == 10'd0, "R1 reset result", {21'd0, valid, result}, 32'd0);
        rst_n = 1'b1;
        step();
        check(cs_n == 2'b11 && sclk == 1'b0, "R10 idle after reset", {29'd0, cs_n, sclk}, 32'd6);

        for (int c = 0; c < 16; c++) begin
            pats[0] = 10'h000; pats[1] = 10'h3FF; pats[2] = 10'h2AA; pats[3] = 10'h155;
            pats[4] = 10'((c * 37 + 5) & 10'h3FF);
            for (int p = 0; p < 5; p++) convert(4'(c), pats[p], p == 2);
        end

        // R7: start held high gives one frame only.
        convert(4'd9, 10'h1C3, 1'b0);
        go = 1'b1;
        begin
            int f0;
            step();
            f0 = frames;
            for (int k = 0; k < 2 * FRAME; k++) step();
            check(frames == f0 + 1 && cs_n == 2'b11 && valid == 1'b1,
                  "R7 held start gives one frame", frames, f0 + 1);
            check(result == 10'h1C3 || frames != f0 + 1, "R7 held start result", {22'd0, result}, 32'h1C3);
        end
        go = 1'b0;
        step();

        // R8: channel changes without a start edge.
        keep = result;
        for (int c = 0; c < 16; c++) begin
            chan = 4'(c);
            step(); step();
        end
        check(valid == 1'b1, "R8 valid kept on channel change", {31'd0, valid}, 32'd1);
        check(result == keep, "R8 result kept on channel change", {22'd0, result}, {22'd0, keep});
        check(cs_n == 2'b11, "R8 no chip select on channel change", {30'd0, cs_n}, 32'd3);
        check(mosi_bad == 0, "R3 command line low outside address slots", mosi_bad, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule